// File: doc/BRIEF.md
# Keyboard Receive Register Block

This block is the receive side of a memory-mapped serial terminal port. An upstream receiver hands it finished characters through a one-cycle valid strobe carrying an 8-bit code and a break flag. The block latches each character, raises a done flag, and drives a level interrupt request toward the processor when interrupts are enabled.

Software reaches the block over a simple word-addressed peripheral bus with byte enables. It can see two registers. Address bit 1 picks between them: 0 selects the control/status register (CSR) and 1 selects the receive buffer. Any address with a bit above bit 1 set falls outside the window and is answered with a bus error. Read data and the error flag are combinational in the cycle of the request. Side effects of a request take hold at the clock edge that ends it.

Top module: `kbd_rx_regs`

## Requirements
- R1: After reset, the buffer holds 0, done and IE are 0, and `irq` is 0.
- R2: A CSR read returns done in bit 7 and IE in bit 6, with every other bit 0.
- R3: Only IE (bit 6) can be written in the CSR. Done and all other bits ignore write data.
- R4: A CSR write with bit 6 = 0 drops `irq` at the next edge. A CSR write with bit 6 = 1 while done is 1 raises `irq` at the next edge.
- R5: A CSR write with `bus_be[0]` = 0 (high byte only) changes nothing.
- R6: A buffer read returns the latched code in bits 7:0 with the upper bits 0. It clears done and drops `irq` at the next edge.
- R7: A buffer write is accepted with no error and changes neither the buffer, done nor `irq`.
- R8: A `ch_valid` strobe latches `ch_code` into the buffer and sets done. `irq` rises at the next edge if IE is 1 and stays 0 otherwise.
- R9: A strobe with `ch_break` = 1 loads 0 into the buffer instead of the code, and is otherwise handled as a normal character.
- R10: A request whose address has any bit above bit 1 set returns `bus_err` = 1 and read data 0, and has no effect.
- R11: When a character arrives in the same cycle as a buffer read, the read returns the old character, and after the edge done is 1 and `irq` follows IE.
- R12: `irq` is a registered level equal to done AND IE. It stays high until a buffer read, an IE=0 write or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bit 1 selects the register |
| bus_be | input | 2 | Byte enables, bit 0 = low byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (0 when not reading) |
| bus_err | output | 1 | Non-existent register response |
| ch_valid | input | 1 | Character-valid strobe from the receiver |
| ch_code | input | 8 | Received character code |
| ch_break | input | 1 | Break indication with the strobe |
| irq | output | 1 | Level interrupt request |

## Verification
The bench enables interrupts after a character is already waiting. A design that only raised the request when a character arrived would leave `irq` low in that case. It writes all-ones apart from bit 6, to catch a CSR that lets done or spare bits be written. It also writes only the high byte, which a design ignoring the byte enables would treat as an IE clear. Other vectors send a break strobe, write into the buffer, and use an out-of-window address. Each of these exposes a buffer that keeps the code, accepts bus data, or decodes too few address bits. One vector puts a character arrival and a buffer read in the same cycle. A design giving the read priority would lose the new done flag and its interrupt.

// File: rtl/kbd_rx_regs.sv
`timescale 1ns/1ps
module kbd_rx_regs #(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 16,
  parameter int CHAR_W   = 8,
  parameter int DONE_BIT = 7,
  parameter int IE_BIT   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic              ch_valid,
  input  logic [CHAR_W-1:0] ch_code,
  input  logic              ch_break,
  output logic              irq
);
  localparam int SEL_BIT = 1;

  logic              done_q, ie_q, irq_q;
  logic [CHAR_W-1:0] buf_q;
  logic              done_n, ie_n;
  logic [DATA_W-1:0] csr_img;

  wire outside = |bus_addr[ADDR_W-1:SEL_BIT+1];
  wire hit     = bus_req & ~outside;
  wire csr_sel = hit & ~bus_addr[SEL_BIT];
  wire buf_sel = hit &  bus_addr[SEL_BIT];
  wire csr_wr  = csr_sel & bus_we & bus_be[0];
  wire buf_rd  = buf_sel & ~bus_we;

  assign ie_n   = csr_wr ? bus_wdata[IE_BIT] : ie_q;
  assign done_n = ch_valid ? 1'b1 : (buf_rd ? 1'b0 : done_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ie_q   <= 1'b0;
      irq_q  <= 1'b0;
      buf_q  <= '0;
    end else begin
      done_q <= done_n;
      ie_q   <= ie_n;
      irq_q  <= done_n & ie_n;
      if (ch_valid) buf_q <= ch_break ? '0 : ch_code;
    end
  end

  always_comb begin
    csr_img           = '0;
    csr_img[DONE_BIT] = done_q;
    csr_img[IE_BIT]   = ie_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (!bus_we) begin
      if (csr_sel)      bus_rdata = csr_img;
      else if (buf_sel) bus_rdata = {{(DATA_W-CHAR_W){1'b0}}, buf_q};
    end
  end

  assign bus_err = bus_req & outside;
  assign irq     = irq_q;
endmodule

// File: rtl/kbd_rx_regs_chk.sv
`timescale 1ns/1ps
module kbd_rx_regs_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_be,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_err,
  input logic              ch_valid,
  input logic              ch_break,
  input logic              irq,
  input logic              done_q,
  input logic              ie_q,
  input logic [CHAR_W-1:0] buf_q
);
  wire in_win  = ~|bus_addr[ADDR_W-1:2];
  wire csr_rd  = bus_req & ~bus_we & in_win & ~bus_addr[1];
  wire csr_wr  = bus_req & bus_we & in_win & ~bus_addr[1] & bus_be[0];
  wire buf_rd  = bus_req & ~bus_we & in_win & bus_addr[1];

  assert_csr_spare_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rd |-> ((bus_rdata & ~16'h00C0) == '0));
  assert_ie_clear_drops_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && !bus_wdata[6]) |=> !irq);
  assert_buf_read_drops_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd && !ch_valid) |=> (!irq && !done_q));
  assert_char_sets_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ch_valid |=> done_q);
  assert_break_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_valid && ch_break) |=> (buf_q == '0));
  assert_outside_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !in_win) |-> (bus_err && bus_rdata == '0));
  assert_irq_level_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (done_q && ie_q));
endmodule

bind kbd_rx_regs kbd_rx_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
  .ch_valid(ch_valid), .ch_break(ch_break), .irq(irq), .done_q(done_q), .ie_q(ie_q),
  .buf_q(buf_q));

// File: tb/kbd_rx_regs_test.sv
`timescale 1ns/1ps
module kbd_rx_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_err;
  logic        ch_valid = 1'b0, ch_break = 1'b0;
  logic [7:0]  ch_code = '0;
  logic        irq;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  kbd_rx_regs uut (.clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .ch_valid(ch_valid), .ch_code(ch_code), .ch_break(ch_break), .irq(irq));

  typedef struct packed {
    logic [7:0]  req;
    logic        rd, wr, ch, brk;
    logic [2:0]  addr;
    logic [1:0]  be;
    logic [15:0] wd;
    logic [7:0]  code;
    logic [15:0] exp_rd;
    logic        exp_err, exp_irq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{8'd1, 1'b1,1'b0,1'b0,1'b0, 3'd0,2'b11,16'h0000,8'h00,16'h0000,1'b0,1'b0}, // R1 csr after reset
    '{8'd8, 1'b0,1'b0,1'b1,1'b0, 3'd0,2'b11,16'h0000,8'h41,16'h0000,1'b0,1'b0}, // R8 char, IE=0
    '{8'd2, 1'b1,1'b0,1'b0,1'b0, 3'd0,2'b11,16'h0000,8'h00,16'h0080,1'b0,1'b0}, // R2 done visible
    '{8'd4, 1'b0,1'b1,1'b0,1'b0, 3'd0,2'b01,16'h0040,8'h00,16'h0000,1'b0,1'b1}, // R4 enable while done
    '{8'd2, 1'b1,1'b0,1'b0,1'b0, 3'd0,2'b11,16'h0000,8'h00,16'h00C0,1'b0,1'b1}, // R2
    '{8'd6, 1'b1,1'b0,1'b0,1'b0, 3'd2,2'b11,16'h0000,8'h00,16'h0041,1'b0,1'b0}, // R6 buffer read
    '{8'd6, 1'b1,1'b0,1'b0,1'b0, 3'd0,2'b11,16'h0000,8'h00,16'h0040,1'b0,1'b0}, // R6 done cleared
    '{8'd9, 1'b0,1'b0,1'b1,1'b1, 3'd0,2'b11,16'h0000,8'h5A,16'h0000,1'b0,1'b1}, // R9 break
    '{8'd9, 1'b1,1'b0,1'b0,1'b0, 3'd2,2'b11,16'h0000,8'h00,16'h0000,1'b0,1'b0}, // R9 buffer is zero
    '{8'd5, 1'b0,1'b1,1'b0,1'b0, 3'd0,2'b10,16'h0000,8'h00,16'h0000,1'b0,1'b0}, // R5 high byte only
    '{8'd5, 1'b1,1'b0,1'b0,1'b0, 3'd0,2'b11,16'h0000,8'h00,16'h0040,1'b0,1'b0}, // R5 IE kept
    '{8'd8, 1'b0,1'b0,1'b1,1'b0, 3'd0,2'b11,16'h0000,8'h33,16'h0000,1'b0,1'b1}, // R8 char, IE=1
    '{8'd7, 1'b0,1'b1,1'b0,1'b0, 3'd2,2'b11,16'h00FF,8'h00,16'h0000,1'b0,1'b1}, // R7 buffer write
    '{8'd7, 1'b1,1'b0,1'b0,1'b0, 3'd0,2'b11,16'h0000,8'h00,16'h00C0,1'b0,1'b1}, // R7 done kept
    '{8'd3, 1'b0,1'b1,1'b0,1'b0, 3'd0,2'b11,16'hFFBF,8'h00,16'h0000,1'b0,1'b0}, // R3 R4 IE=0 write
    '{8'd3, 1'b1,1'b0,1'b0,1'b0, 3'd0,2'b11,16'h0000,8'h00,16'h0080,1'b0,1'b0}, // R3 only IE written
    '{8'd7, 1'b1,1'b0,1'b0,1'b0, 3'd2,2'b11,16'h0000,8'h00,16'h0033,1'b0,1'b0}, // R7 buffer intact
    '{8'd10,1'b1,1'b0,1'b0,1'b0, 3'd4,2'b11,16'h0000,8'h00,16'h0000,1'b1,1'b0}, // R10 outside window
    '{8'd12,1'b0,1'b1,1'b0,1'b0, 3'd0,2'b01,16'h0040,8'h00,16'h0000,1'b0,1'b0}, // R12 IE=1, done=0
    '{8'd11,1'b1,1'b0,1'b1,1'b0, 3'd2,2'b11,16'h0000,8'h80,16'h0033,1'b0,1'b1}  // R11 arrive + read
  };

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input int req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    bus_req = 0; bus_we = 0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
    ch_valid = 0; ch_break = 0; ch_code = '0;
  endtask

  task automatic access(input logic rd, input logic wr, input logic [2:0] a,
                        input logic [1:0] be, input logic [15:0] wd,
                        input logic ch, input logic brk, input logic [7:0] code);
    @(negedge clk);
    bus_req = rd | wr; bus_we = wr; bus_addr = a; bus_be = be; bus_wdata = wd;
    ch_valid = ch; ch_break = brk; ch_code = code;
    #1;
  endtask

  initial begin
    #100000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check({15'd0, irq}, 16'd0, 1, "irq after reset");

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].rd, VEC[i].wr, VEC[i].addr, VEC[i].be, VEC[i].wd,
             VEC[i].ch, VEC[i].brk, VEC[i].code);
      if (VEC[i].rd) check(bus_rdata, VEC[i].exp_rd, VEC[i].req, $sformatf("rdata v%0d", i));
      check({15'd0, bus_err}, {15'd0, VEC[i].exp_err}, VEC[i].req, $sformatf("err v%0d", i));
      @(negedge clk);
      idle();
      check({15'd0, irq}, {15'd0, VEC[i].exp_irq}, VEC[i].req, $sformatf("irq v%0d", i));
    end

    // R11: new character now in buffer; read clears it
    access(1, 0, 3'd2, 2'b11, 16'h0, 0, 0, 8'h0);
    check(bus_rdata, 16'h0080, 11, "new char after collision");
    @(negedge clk); idle();
    check({15'd0, irq}, 16'd0, 6, "irq after read");

    // R10: write outside window has no effect on IE
    access(0, 1, 3'd6, 2'b11, 16'h0000, 0, 0, 8'h0);
    check({15'd0, bus_err}, 16'd1, 10, "write err");
    @(negedge clk); idle();
    access(1, 0, 3'd0, 2'b11, 16'h0, 0, 0, 8'h0);
    check(bus_rdata, 16'h0040, 10, "IE untouched by outside write");
    @(negedge clk); idle();

    // R1: reset in the middle of activity
    access(0, 0, 3'd0, 2'b11, 16'h0, 1, 0, 8'h77);
    @(negedge clk); idle();
    check({15'd0, irq}, 16'd1, 8, "irq before reset");
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check({15'd0, irq}, 16'd0, 1, "irq cleared by reset");
    access(1, 0, 3'd0, 2'b11, 16'h0, 0, 0, 8'h0);
    check(bus_rdata, 16'h0000, 1, "csr cleared by reset");
    @(negedge clk); idle();
    access(1, 0, 3'd2, 2'b11, 16'h0, 0, 0, 8'h0);
    check(bus_rdata, 16'h0000, 1, "buffer cleared by reset");
    @(negedge clk); idle();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule